// File: doc/BRIEF.md
# Selectable-Order Four-Beat Burst Address Sequencer

This block sits between a synchronous memory's command inputs and its address decoder. On a load edge it captures a full starting address together with the access type (read or write) and the selected ordering. On each following advance edge it produces the next address of a four-beat burst by changing only the two low-order bits. The upper bits keep the value captured at load, and the read or write type captured at load stays in force. Chip selects and the write strobe are not looked at during an advance.

Two beat orders are available, chosen at load time by a mode input. The interleaved order XORs the start value with the beat number. The linear order adds the beat number to the start value and wraps modulo four. A burst that keeps advancing past its fourth beat repeats the same four-address cycle and never carries into the upper bits. An active-low clock enable freezes all state. Byte-lane write enables are sampled again on every beat, so each beat of a write burst can select its own lanes.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released before any command, `acc_valid`=0, `acc_write`=0, `addr_out`=0 and `lane_en_out`=0.
- R2: On an edge with `clk_en_n`=0, `step`=0 and `sel_n`=3'b000, an access starts. After that edge `acc_valid`=1, `addr_out` equals `addr_in`, and `acc_write` is the inverse of `wr_n` (`wr_n`=0 means write).
- R3: On an edge with `clk_en_n`=0 and `step`=0, any `sel_n` bit at 1 deselects. After that edge `acc_valid`=0, `acc_write`=0, `lane_en_out`=0, and `addr_out` is 0 while no access is valid.
- R4: On an edge with `clk_en_n`=0, `step`=1 and an access valid, the burst advances. `sel_n` and `wr_n` are ignored, `acc_valid` and `acc_write` are unchanged, and `addr_out` bits above bit 1 are unchanged.
- R5: With `mode_il`=1 at load, beat k (k=0,1,2,...) drives `addr_out[1:0]` = start XOR (k mod 4), where start is `addr_in[1:0]` at load.
- R6: With `mode_il`=0 at load, beat k drives `addr_out[1:0]` = (start + k) mod 4.
- R7: Advancing beyond the fourth beat continues the same modulo-4 sequence (beat 4 equals beat 0), and the upper address bits never change.
- R8: On an edge with `clk_en_n`=1, all outputs keep their values whatever `step`, `sel_n`, `wr_n`, `mode_il`, `addr_in` and `lane_en` are.
- R9: An advance edge while no access is valid leaves `acc_valid`=0 and `addr_out`=0.
- R10: After each edge that starts or advances a write, `lane_en_out` equals the `lane_en` sampled on that edge. After any edge that leaves a read or no access, `lane_en_out`=0.
- R11: `mode_il` is sampled only on load edges. Changing it during a burst does not alter that burst's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| step | input | 1 | 0 = load a new address, 1 = advance the burst |
| sel_n | input | 3 | Active-low chip selects; all must be 0 to start an access |
| wr_n | input | 1 | Active-low write strobe, sampled on load edges |
| mode_il | input | 1 | 1 = interleaved order, 0 = linear wrap order; sampled at load |
| addr_in | input | ADDR_W | Starting address |
| lane_en | input | NLANE | Byte-lane write enables, sampled every beat |
| addr_out | output | ADDR_W | Address of the current beat, 0 when no access is valid |
| acc_valid | output | 1 | An access is in progress for this beat |
| acc_write | output | 1 | The current access is a write |
| lane_en_out | output | NLANE | Lane enables for the current write beat |

## Verification
The hardest situations to reach are those where the two orders produce different addresses, and those where the mode pin changes inside a burst. For starts 00 and 10 the two sequences are identical, so the stimulus uses starts 01 and 11 to tell the orders apart. It then toggles `mode_il` partway through a linear burst at a beat where the interleaved order would give a different value. Wrap past the fourth beat is reached by advancing five or more times in a row. A frozen (`clk_en_n`=1) edge is placed in mid-burst with every other input changed, so the freeze is checked against a live beat counter.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } cmd_e;
endpackage

// File: rtl/burst_cmd_qual.sv
module burst_cmd_qual
    import burst_seq_pkg::*;
#(
    parameter int NSEL = 3
) (
    input  logic            clk_en_n,
    input  logic            step,
    input  logic [NSEL-1:0] sel_n,
    input  logic            active,
    output cmd_e            cmd
);
    logic all_sel;

    always_comb begin
        all_sel = (sel_n == '0);
        if (clk_en_n) begin
            cmd = CMD_HOLD;
        end else if (!step) begin
            cmd = all_sel ? CMD_LOAD : CMD_DESEL;
        end else begin
            // selects and write strobe are never consulted on an advance
            cmd = active ? CMD_STEP : CMD_HOLD;
        end
    end
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] il_low;

    always_comb begin
        lin_low = start + beat;
        il_low  = start ^ beat;
        low     = interleave ? il_low : lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int NLANE  = 4,
    parameter int NSEL   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              step,
    input  logic [NSEL-1:0]   sel_n,
    input  logic              wr_n,
    input  logic              mode_il,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [NLANE-1:0]  lane_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [NLANE-1:0]  lane_en_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              interleave;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic [NLANE-1:0]  lanes;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    cmd_e              cmd;
    logic [BEAT_W-1:0] low;

    burst_cmd_qual #(.NSEL(NSEL)) qual_i (
        .clk_en_n (clk_en_n),
        .step     (step),
        .sel_n    (sel_n),
        .active   (st_q.valid),
        .cmd      (cmd)
    );

    burst_order_gen order_i (
        .start      (st_q.base[BEAT_W-1:0]),
        .beat       (st_q.beat),
        .interleave (st_q.interleave),
        .low        (low)
    );

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.valid      = 1'b1;
                st_d.write      = ~wr_n;
                st_d.interleave = mode_il;
                st_d.base       = addr_in;
                st_d.beat       = '0;
                st_d.lanes      = wr_n ? '0 : lane_en;
            end
            CMD_DESEL: begin
                st_d.valid = 1'b0;
                st_d.write = 1'b0;
                st_d.beat  = '0;
                st_d.lanes = '0;
            end
            CMD_STEP: begin
                st_d.beat  = st_q.beat + 1'b1;
                st_d.lanes = st_q.write ? lane_en : '0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out    = st_q.valid ? {st_q.base[ADDR_W-1:BEAT_W], low} : '0;
    assign acc_valid   = st_q.valid;
    assign acc_write   = st_q.write;
    assign lane_en_out = st_q.lanes;

    // R8: a frozen edge changes nothing visible
    a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && $past(rst_n)) |=> ($stable(addr_out) && $stable(acc_valid)
                            && $stable(acc_write) && $stable(lane_en_out)));

    // R4: advancing keeps valid, type and upper bits
    a_r4_step_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && step && acc_valid) |=> (acc_valid && $stable(acc_write)
                            && $stable(addr_out[ADDR_W-1:BEAT_W])));

    // R9: advancing with nothing in progress stays idle
    a_r9_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && step && !acc_valid) |=> (!acc_valid && addr_out == '0));

    // R3: deselect on a load edge ends any access
    a_r3_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !step && sel_n != '0) |=> (!acc_valid && !acc_write));

    // R6: linear order steps the low bits by one, modulo four
    a_r6_linear_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && !st_q.interleave) |=>
            (addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1)));

    // R10: no lane enables outside a write
    a_r10_lanes_read: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_write |-> (lane_en_out == '0));

    initial begin
        if (HI_W < 1) $error("ADDR_W must exceed BEAT_W");
    end
endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
    localparam int AW = 18;
    localparam int NL = 4;

    typedef struct packed {
        logic [3:0]    req;
        logic          cen_n;
        logic          stp;
        logic [2:0]    seln;
        logic          wrn;
        logic          mode;
        logic [AW-1:0] addr;
        logic [NL-1:0] lanes;
        logic          e_v;
        logic          e_w;
        logic [AW-1:0] e_a;
        logic [NL-1:0] e_l;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R2 load read, interleaved, start 01
        '{4'd2,  1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 18'h12341, 4'hF, 1'b1, 1'b0, 18'h12341, 4'h0},
        // R5 R4 step, selects/strobe ignored: 00
        '{4'd5,  1'b0, 1'b1, 3'b111, 1'b0, 1'b1, 18'h00000, 4'hF, 1'b1, 1'b0, 18'h12340, 4'h0},
        // R5 beat 2: 11
        '{4'd5,  1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 18'h00000, 4'h0, 1'b1, 1'b0, 18'h12343, 4'h0},
        // R5 beat 3: 10
        '{4'd5,  1'b0, 1'b1, 3'b000, 1'b1, 1'b1, 18'h3FFFF, 4'h0, 1'b1, 1'b0, 18'h12342, 4'h0},
        // R7 beat 4 wraps to start
        '{4'd7,  1'b0, 1'b1, 3'b000, 1'b1, 1'b1, 18'h00000, 4'h0, 1'b1, 1'b0, 18'h12341, 4'h0},
        // R2 R10 load write, linear, start 01
        '{4'd10, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 18'h0ABC1, 4'h5, 1'b1, 1'b1, 18'h0ABC1, 4'h5},
        // R6 R10 step: 10, new lanes, strobe high ignored (R4)
        '{4'd6,  1'b0, 1'b1, 3'b101, 1'b1, 1'b0, 18'h00000, 4'hA, 1'b1, 1'b1, 18'h0ABC2, 4'hA},
        // R6 step: 11
        '{4'd6,  1'b0, 1'b1, 3'b000, 1'b1, 1'b0, 18'h00000, 4'hF, 1'b1, 1'b1, 18'h0ABC3, 4'hF},
        // R8 frozen edge with everything else changed
        '{4'd8,  1'b1, 1'b0, 3'b010, 1'b1, 1'b1, 18'h2AAAA, 4'h0, 1'b1, 1'b1, 18'h0ABC3, 4'hF},
        // R11 mode flipped mid-burst, linear continues: 00 (interleaved would be 10)
        '{4'd11, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 18'h00000, 4'h3, 1'b1, 1'b1, 18'h0ABC0, 4'h3},
        // R7 beat 4 back to start, upper not carried
        '{4'd7,  1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 18'h00000, 4'h3, 1'b1, 1'b1, 18'h0ABC1, 4'h3},
        // R3 deselect
        '{4'd3,  1'b0, 1'b0, 3'b010, 1'b0, 1'b1, 18'h11111, 4'hF, 1'b0, 1'b0, 18'h00000, 4'h0},
        // R9 step while idle
        '{4'd9,  1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 18'h11111, 4'hF, 1'b0, 1'b0, 18'h00000, 4'h0},
        // R2 load write, interleaved, start 11
        '{4'd2,  1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 18'h3FFFF, 4'hC, 1'b1, 1'b1, 18'h3FFFF, 4'hC},
        // R5 beat 1: 10
        '{4'd5,  1'b0, 1'b1, 3'b000, 1'b1, 1'b0, 18'h00000, 4'h1, 1'b1, 1'b1, 18'h3FFFE, 4'h1},
        // R5 beat 2: 01
        '{4'd5,  1'b0, 1'b1, 3'b000, 1'b1, 1'b0, 18'h00000, 4'h2, 1'b1, 1'b1, 18'h3FFFD, 4'h2},
        // R5 beat 3: 00
        '{4'd5,  1'b0, 1'b1, 3'b000, 1'b1, 1'b0, 18'h00000, 4'h4, 1'b1, 1'b1, 18'h3FFFC, 4'h4},
        // R7 beat 4: 11, upper kept
        '{4'd7,  1'b0, 1'b1, 3'b000, 1'b1, 1'b0, 18'h00000, 4'h8, 1'b1, 1'b1, 18'h3FFFF, 4'h8},
        // R6 load read, linear, start 11
        '{4'd6,  1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 18'h00003, 4'hF, 1'b1, 1'b0, 18'h00003, 4'h0},
        // R7 linear wrap 11 -> 00 without carry
        '{4'd7,  1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 18'h00000, 4'hF, 1'b1, 1'b0, 18'h00000, 4'h0},
        // R10 read beat keeps lanes at zero
        '{4'd10, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 18'h00000, 4'hF, 1'b1, 1'b0, 18'h00001, 4'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          step = 1'b0;
    logic [2:0]    sel_n = 3'b111;
    logic          wr_n = 1'b1;
    logic          mode_il = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [NL-1:0] lane_en = '0;
    logic [AW-1:0] addr_out;
    logic          acc_valid;
    logic          acc_write;
    logic [NL-1:0] lane_en_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .NLANE(NL), .NSEL(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .step(step),
        .sel_n(sel_n), .wr_n(wr_n), .mode_il(mode_il), .addr_in(addr_in),
        .lane_en(lane_en), .addr_out(addr_out), .acc_valid(acc_valid),
        .acc_write(acc_write), .lane_en_out(lane_en_out)
    );

    task automatic check(input int req, input logic v, input logic w,
                         input logic [AW-1:0] a, input logic [NL-1:0] l);
        n_checks++;
        if (acc_valid !== v || acc_write !== w || addr_out !== a || lane_en_out !== l) begin
            n_fail++;
            $display("FAIL R%0d: got v=%b w=%b a=%h l=%h, expected v=%b w=%b a=%h l=%h",
                     req, acc_valid, acc_write, addr_out, lane_en_out, v, w, a, l);
        end
    endtask

    task automatic apply(input vec_t t);
        @(negedge clk);
        clk_en_n = t.cen_n;
        step     = t.stp;
        sel_n    = t.seln;
        wr_n     = t.wrn;
        mode_il  = t.mode;
        addr_in  = t.addr;
        lane_en  = t.lanes;
        @(posedge clk);
        #1;
        check(int'(t.req), t.e_v, t.e_w, t.e_a, t.e_l);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 during reset
        repeat (3) @(posedge clk);
        #1;
        check(1, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        clk_en_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, 1'b0, 1'b0, '0, '0); // R1 after release

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
        end

        // R1 reset mid-burst: load write then reset
        apply('{4'd2, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 18'h05555, 4'h6,
                1'b1, 1'b1, 18'h05555, 4'h6});
        @(negedge clk);
        rst_n = 1'b0;
        step = 1'b1;
        @(posedge clk);
        #1;
        check(1, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 advance right after reset stays idle
        apply('{4'd9, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 18'h05555, 4'hF,
                1'b0, 1'b0, 18'h00000, 4'h0});
        // R8 freeze on an idle block with a load pattern present
        apply('{4'd8, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 18'h01234, 4'hF,
                1'b0, 1'b0, 18'h00000, 4'h0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule